// File: doc/BRIEF.md
# Receive-Enable Delay Training Sequencer

This block trains the receive-enable delay of one memory channel that carries a set of byte groups (four by default). Each group owns a delay tuple made of a clock count, a preamble offset, a half-cycle phase, a tap and a fine tap. The sequencer moves one tuple at a time. It commits every change before it asks the memory side for a probe read. When the read is acknowledged it captures the strobe level of the group's two lanes. From those levels it decides the next move. First it leaves any high region. Then it walks onto the rising strobe edge and backs up whole clocks until it finds the quiet preamble. It locates the edge a second time and settles half a cycle before it.

When every group has finished, the sequencer takes the smallest clock count among the groups. That value becomes the shared count, and each group keeps its excess in its preamble offset. A done flag then stays high until the next start. If a carry pushes the clock count out of range, or if a search phase runs too long, the sequence stops and an error flag stays high instead.

Top module: `rcal_seq`

## Requirements
- R1: A start pulse, accepted when idle, done or in error, loads every group with clock count `cas_lat`+1 and all other fields zero, and clears done and err. Groups are then trained in index order 0 to NGRP-1.
- R2: `probe_req` stays high with a stable `probe_grp` until `probe_ack`. `lane_hi` (bit 0 = first lane, bit 1 = second lane, 1 = strobe high) is captured in the acknowledge cycle, and each acknowledge ends exactly one probe.
- R3: Leaving high: while either lane reads high, the group takes a quarter step and probes again. A quarter step adds T_BOUND/2 taps, plus P_BOUND/2 fine taps when T_BOUND is odd.
- R4: Edge search: add 2 taps. Then take quarter steps until at least one lane is high, back off one quarter step, and add one fine tap at a time until both lanes are high.
- R5: After the first edge search the group takes one quarter step. It then subtracts one clock count while either lane reads high.
- R6: A second edge search follows. Then the phase drops by 2, and one tap is added when `card_f` is 1, which completes the group.
- R7: After the last group, every clock count equals the minimum clock count over all groups, each preamble offset equals that group's count minus the minimum, and done rises.
- R8: The timing outputs do not change while a probe is pending. Every delay change is visible before the probe that follows it.
- R9: Tuples stay normalized, with fine tap below P_BOUND, tap below T_BOUND and phase 0 or 2. A fine-tap carry moves one tap, a tap carry moves the phase by 2, and a phase carry moves the clock count. The position in fine units is ((c*2 + ph/2)*T_BOUND + t)*P_BOUND + p.
- R10: If a step would give a clock count below 0 or above 15, err rises, done stays low, that step is not committed, and no further probe is issued before the next start.
- R11: If a search phase would continue after MAX_ITER probes within that phase, err rises after the MAX_ITER-th probe, with done low and no further probe.
- R12: Done, err and all timing outputs hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a training run |
| cas_lat | input | CAS_W | Read latency; initial clock count is this plus one |
| card_f | input | 1 | Add one tap at the end of each group |
| probe_req | output | 1 | Probe read requested |
| probe_grp | output | $clog2(NGRP) | Group being probed |
| probe_ack | input | 1 | Probe read completed; lane levels valid |
| lane_hi | input | 2 | Strobe levels of the group's two lanes |
| tim_c | output | NGRP*4 | Clock count per group |
| tim_pre | output | NGRP*4 | Preamble offset per group |
| tim_ph | output | NGRP*2 | Half-cycle phase per group |
| tim_t | output | NGRP*4 | Tap per group |
| tim_p | output | NGRP*3 | Fine tap per group |
| done | output | 1 | Training finished |
| err | output | 1 | Training aborted |

## Verification
A wrong phase decision or a lost carry shows up in the next probe. The lane levels the strobe model returns then differ from the reference walk. The difference spreads into the probe count and the final tuples of that group within a few probes. A delay that is committed late produces the same kind of divergence at the very first probe after the step. Wrong minimum extraction or wrong abort handling is visible on the done, err and preamble outputs in the cycle the run ends.

// File: rtl/rcal_pkg.sv
package rcal_pkg;
    localparam int C_W     = 4;
    localparam int PRE_W   = 4;
    localparam int PH_W    = 2;
    localparam int T_W     = 4;
    localparam int P_W     = 3;
    localparam int D_W     = 6;
    localparam int C_BOUND = 1 << C_W;
    localparam int PH_BOUND = 4;

    typedef struct packed {
        logic [C_W-1:0]   c;
        logic [PRE_W-1:0] pre;
        logic [PH_W-1:0]  ph;
        logic [T_W-1:0]   t;
        logic [P_W-1:0]   p;
    } rtime_t;

    typedef struct packed {
        logic [D_W-1:0] dc;
        logic [D_W-1:0] dph;
        logic [D_W-1:0] dt;
        logic [D_W-1:0] dp;
    } rstep_t;

    typedef enum logic [2:0] {PH_LOW, PH_HI, PH_FINE, PH_PRE, PH_END} rphase_e;
    typedef enum logic [2:0] {S_IDLE, S_PROBE, S_APPLY, S_FACTOR, S_DONE, S_ERR} rstate_e;
endpackage

// File: rtl/rcal_norm.sv
module rcal_norm
    import rcal_pkg::*;
#(
    parameter int T_BOUND = 9,
    parameter int P_BOUND = 8
) (
    input  rtime_t cur,
    input  rstep_t step,
    output rtime_t nxt,
    output logic   ovf
);
    localparam logic signed [7:0] PB = 8'(P_BOUND);
    localparam logic signed [7:0] TB = 8'(T_BOUND);
    localparam logic signed [7:0] HB = 8'(PH_BOUND);
    localparam logic signed [7:0] CB = 8'(C_BOUND);

    logic signed [7:0] p1, p2, cp, t1, t2, ct, ph1, ph2, cph, c1;

    always_comb begin
        p1 = $signed(8'(cur.p)) + 8'($signed(step.dp));
        if (p1 >= PB) begin
            cp = 8'sd1; p2 = p1 - PB;
        end else if (p1 < 8'sd0) begin
            cp = -8'sd1; p2 = p1 + PB;
        end else begin
            cp = 8'sd0; p2 = p1;
        end
        t1 = $signed(8'(cur.t)) + 8'($signed(step.dt)) + cp;
        if (t1 >= TB) begin
            ct = 8'sd1; t2 = t1 - TB;
        end else if (t1 < 8'sd0) begin
            ct = -8'sd1; t2 = t1 + TB;
        end else begin
            ct = 8'sd0; t2 = t1;
        end
        ph1 = $signed(8'(cur.ph)) + 8'($signed(step.dph)) + ct + ct;
        if (ph1 >= HB) begin
            cph = 8'sd1; ph2 = ph1 - HB;
        end else if (ph1 < 8'sd0) begin
            cph = -8'sd1; ph2 = ph1 + HB;
        end else begin
            cph = 8'sd0; ph2 = ph1;
        end
        c1  = $signed(8'(cur.c)) + 8'($signed(step.dc)) + cph;
        ovf = (c1 < 8'sd0) || (c1 >= CB);
        nxt     = cur;
        nxt.c   = c1[C_W-1:0];
        nxt.ph  = ph2[PH_W-1:0];
        nxt.t   = t2[T_W-1:0];
        nxt.p   = p2[P_W-1:0];
    end
endmodule

// File: rtl/rcal_cmin.sv
module rcal_cmin
    import rcal_pkg::*;
#(
    parameter int NGRP = 4
) (
    input  logic [NGRP*C_W-1:0] cvals,
    output logic [C_W-1:0]      cmin
);
    always_comb begin
        cmin = cvals[C_W-1:0];
        for (int g = 1; g < NGRP; g++) begin
            if (cvals[g*C_W +: C_W] < cmin) cmin = cvals[g*C_W +: C_W];
        end
    end
endmodule

// File: rtl/rcal_seq.sv
module rcal_seq
    import rcal_pkg::*;
#(
    parameter int NGRP     = 4,
    parameter int T_BOUND  = 9,
    parameter int P_BOUND  = 8,
    parameter int MAX_ITER = 64,
    parameter int CAS_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [CAS_W-1:0]            cas_lat,
    input  logic                        card_f,
    output logic                        probe_req,
    output logic [$clog2(NGRP)-1:0]     probe_grp,
    input  logic                        probe_ack,
    input  logic [1:0]                  lane_hi,
    output logic [NGRP*C_W-1:0]         tim_c,
    output logic [NGRP*PRE_W-1:0]       tim_pre,
    output logic [NGRP*PH_W-1:0]        tim_ph,
    output logic [NGRP*T_W-1:0]         tim_t,
    output logic [NGRP*P_W-1:0]         tim_p,
    output logic                        done,
    output logic                        err
);
    localparam int GW   = $clog2(NGRP);
    localparam int IT_W = $clog2(MAX_ITER + 1);
    localparam int QT   = T_BOUND / 2;
    localparam int QP   = (T_BOUND % 2) * (P_BOUND / 2);

    typedef struct packed {
        rstate_e               st;
        rphase_e               ph;
        logic                  pass2;
        logic [GW-1:0]         grp;
        logic [IT_W-1:0]       iter;
        rstep_t                step;
        rtime_t [NGRP-1:0]     tim;
    } seq_s;

    function automatic rstep_t mk(input int dc, input int dph, input int dt, input int dp);
        rstep_t s;
        s.dc = D_W'(dc); s.dph = D_W'(dph); s.dt = D_W'(dt); s.dp = D_W'(dp);
        return s;
    endfunction

    localparam rstep_t Q_FWD = mk(0, 0, QT, QP);
    localparam rstep_t Q_BCK = mk(0, 0, -QT, -QP);

    seq_s   q, d;
    rtime_t norm_out;
    logic   norm_ovf;
    logic   stay;
    logic [C_W-1:0] cmin;

    rcal_norm #(.T_BOUND(T_BOUND), .P_BOUND(P_BOUND)) u_norm (
        .cur (q.tim[q.grp]),
        .step(q.step),
        .nxt (norm_out),
        .ovf (norm_ovf)
    );

    rcal_cmin #(.NGRP(NGRP)) u_cmin (
        .cvals(tim_c),
        .cmin (cmin)
    );

    always_comb begin
        d    = q;
        stay = 1'b0;
        case (q.st)
            S_IDLE, S_DONE, S_ERR: begin
                if (start) begin
                    for (int g = 0; g < NGRP; g++) begin
                        d.tim[g]   = '0;
                        d.tim[g].c = C_W'(cas_lat) + C_W'(1);
                    end
                    d.st    = S_PROBE;
                    d.ph    = PH_LOW;
                    d.pass2 = 1'b0;
                    d.grp   = '0;
                    d.iter  = '0;
                end
            end
            S_PROBE: begin
                if (probe_ack) begin
                    case (q.ph)
                        PH_LOW: begin
                            if (|lane_hi) begin
                                d.step = Q_FWD; stay = 1'b1;
                            end else begin
                                d.step = mk(0, 0, 2, 0); d.ph = PH_HI;
                            end
                        end
                        PH_HI: begin
                            if (!(|lane_hi)) begin
                                d.step = Q_FWD; stay = 1'b1;
                            end else begin
                                d.step = Q_BCK; d.ph = PH_FINE;
                            end
                        end
                        PH_FINE: begin
                            if (!(&lane_hi)) begin
                                d.step = mk(0, 0, 0, 1); stay = 1'b1;
                            end else if (!q.pass2) begin
                                d.step = Q_FWD; d.ph = PH_PRE;
                            end else begin
                                d.step = mk(0, -2, card_f ? 1 : 0, 0); d.ph = PH_END;
                            end
                        end
                        PH_PRE: begin
                            if (|lane_hi) begin
                                d.step = mk(-1, 0, 0, 0); stay = 1'b1;
                            end else begin
                                d.step = mk(0, 0, 2, 0); d.ph = PH_HI; d.pass2 = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                    d.st = S_APPLY;
                    if (stay) begin
                        if (q.iter == IT_W'(MAX_ITER - 1)) d.st = S_ERR;
                        else d.iter = q.iter + 1'b1;
                    end else begin
                        d.iter = '0;
                    end
                end
            end
            S_APPLY: begin
                if (norm_ovf) begin
                    d.st = S_ERR;
                end else begin
                    d.tim[q.grp] = norm_out;
                    d.st = S_PROBE;
                    if (q.ph == PH_END) begin
                        if (q.grp == GW'(NGRP - 1)) begin
                            d.st = S_FACTOR;
                        end else begin
                            d.grp   = q.grp + 1'b1;
                            d.ph    = PH_LOW;
                            d.pass2 = 1'b0;
                            d.iter  = '0;
                        end
                    end
                end
            end
            S_FACTOR: begin
                for (int g = 0; g < NGRP; g++) begin
                    d.tim[g].pre = PRE_W'(q.tim[g].c - cmin);
                    d.tim[g].c   = cmin;
                end
                d.st = S_DONE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign probe_req = (q.st == S_PROBE);
    assign probe_grp = q.grp;
    assign done      = (q.st == S_DONE);
    assign err       = (q.st == S_ERR);

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_out
        assign tim_c  [gi*C_W   +: C_W]   = q.tim[gi].c;
        assign tim_pre[gi*PRE_W +: PRE_W] = q.tim[gi].pre;
        assign tim_ph [gi*PH_W  +: PH_W]  = q.tim[gi].ph;
        assign tim_t  [gi*T_W   +: T_W]   = q.tim[gi].t;
        assign tim_p  [gi*P_W   +: P_W]   = q.tim[gi].p;

        // R9
        range_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(tim_t[gi*T_W +: T_W]) < T_BOUND) && (32'(tim_p[gi*P_W +: P_W]) < P_BOUND)
            && !tim_ph[gi*PH_W])
            else $error("tuple out of range");

        // R7
        common_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (tim_c[gi*C_W +: C_W] == tim_c[C_W-1:0]))
            else $error("clock counts differ after done");
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && !probe_ack) |=> (probe_req && $stable(probe_grp)))
        else $error("probe request dropped early");

    // R8
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && $past(probe_req)) |-> ($stable(tim_c) && $stable(tim_ph)
            && $stable(tim_t) && $stable(tim_p)))
        else $error("delay moved during probe");

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> (err && !probe_req && $stable(tim_c) && $stable(tim_t)))
        else $error("error state not held");

    // R12
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(tim_c) && $stable(tim_pre) && $stable(tim_t)))
        else $error("done state not held");
endmodule

// File: tb/rcal_seq_test.sv
`timescale 1ns/1ps
module rcal_seq_test;
    localparam int NG = 4;
    localparam int TB = 9;
    localparam int PB = 8;
    localparam int MAXIT = 64;
    localparam int CLKU = 2 * TB * PB;
    localparam int HALFU = TB * PB;

    logic clk = 1'b0;
    logic rst_n, start, card_f, probe_req, probe_ack, done, err;
    logic [3:0] cas_lat;
    logic [1:0] probe_grp, lane_hi;
    logic [NG*4-1:0] tim_c, tim_pre, tim_t;
    logic [NG*2-1:0] tim_ph;
    logic [NG*3-1:0] tim_p;

    always #4 clk = ~clk;

    rcal_seq #(.NGRP(NG), .T_BOUND(TB), .P_BOUND(PB), .MAX_ITER(MAXIT), .CAS_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cas_lat(cas_lat), .card_f(card_f),
        .probe_req(probe_req), .probe_grp(probe_grp), .probe_ack(probe_ack), .lane_hi(lane_hi),
        .tim_c(tim_c), .tim_pre(tim_pre), .tim_ph(tim_ph), .tim_t(tim_t), .tim_p(tim_p),
        .done(done), .err(err)
    );

    int total = 0, bad = 0, nprobe = 0, lat = 0, wcnt = 0, mode = 0;
    bit fin = 0;
    int e0 [NG], e1 [NG];
    int rc [NG], rpre [NG], rph [NG], rt [NG], rp [NG];
    int rprobes;
    bit ab;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pos(input int c, input int ph, input int t, input int p);
        return ((c * 2 + ph / 2) * TB + t) * PB + p;
    endfunction

    function automatic bit lv(input int g, input int ln, input int u);
        int e;
        if (mode == 2) return 1'b1;
        if (mode == 1 && ln == 1) return 1'b0;
        e = ln ? e1[g] : e0[g];
        if (u < e) return 1'b0;
        return ((u - e) % CLKU) < HALFU;
    endfunction

    // probe responder
    initial begin
        probe_ack = 1'b0;
        lane_hi = 2'b00;
        forever begin
            @(negedge clk);
            if (probe_req && !probe_ack) begin
                if (wcnt >= lat) begin
                    automatic int g = int'(probe_grp);
                    automatic int u = pos(int'(tim_c[g*4 +: 4]), int'(tim_ph[g*2 +: 2]),
                                          int'(tim_t[g*4 +: 4]), int'(tim_p[g*3 +: 3]));
                    lane_hi = {lv(g, 1, u), lv(g, 0, u)};
                    probe_ack = 1'b1;
                    nprobe++;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end else begin
                probe_ack = 1'b0;
            end
        end
    end

    // reference walk, written from the requirements
    task automatic mv(input int g, input int dc, input int dph, input int dt, input int dp);
        int c, ph, t, p;
        if (ab) return;
        c = rc[g] + dc; ph = rph[g] + dph; t = rt[g] + dt; p = rp[g] + dp;
        while (p >= PB) begin t++; p -= PB; end
        while (p < 0) begin t--; p += PB; end
        while (t >= TB) begin ph += 2; t -= TB; end
        while (t < 0) begin ph -= 2; t += TB; end
        while (ph >= 4) begin c++; ph -= 4; end
        while (ph < 0) begin c--; ph += 4; end
        if (c < 0 || c >= 16) ab = 1;
        else begin rc[g] = c; rph[g] = ph; rt[g] = t; rp[g] = p; end
    endtask

    task automatic search(input int g, input int kind);
        bit l0, l1, cont;
        int it = 0;
        int u;
        while (!ab) begin
            u = pos(rc[g], rph[g], rt[g], rp[g]);
            l0 = lv(g, 0, u); l1 = lv(g, 1, u);
            rprobes++;
            case (kind)
                0: cont = l0 | l1;
                1: cont = !(l0 | l1);
                2: cont = !(l0 & l1);
                default: cont = l0 | l1;
            endcase
            if (!cont) break;
            if (it == MAXIT - 1) begin ab = 1; break; end
            it++;
            case (kind)
                0, 1: mv(g, 0, 0, TB / 2, (TB % 2) * (PB / 2));
                2: mv(g, 0, 0, 0, 1);
                default: mv(g, -1, 0, 0, 0);
            endcase
        end
    endtask

    task automatic ref_run(input int cas, input bit cf);
        int m;
        ab = 0; rprobes = 0;
        for (int g = 0; g < NG; g++) begin
            rc[g] = cas + 1; rpre[g] = 0; rph[g] = 0; rt[g] = 0; rp[g] = 0;
        end
        for (int g = 0; g < NG; g++) begin
            if (ab) break;
            search(g, 0);
            if (!ab) mv(g, 0, 0, 2, 0);
            if (!ab) search(g, 1);
            if (!ab) mv(g, 0, 0, -(TB / 2), -((TB % 2) * (PB / 2)));
            if (!ab) search(g, 2);
            if (!ab) mv(g, 0, 0, TB / 2, (TB % 2) * (PB / 2));
            if (!ab) search(g, 3);
            if (!ab) mv(g, 0, 0, 2, 0);
            if (!ab) search(g, 1);
            if (!ab) mv(g, 0, 0, -(TB / 2), -((TB % 2) * (PB / 2)));
            if (!ab) search(g, 2);
            if (!ab) mv(g, 0, -2, cf ? 1 : 0, 0);
        end
        if (!ab) begin
            m = 16;
            for (int g = 0; g < NG; g++) if (rc[g] < m) m = rc[g];
            for (int g = 0; g < NG; g++) begin rpre[g] = rc[g] - m; rc[g] = m; end
        end
    endtask

    task automatic cmp_tuples(input string tag);
        for (int g = 0; g < NG; g++) begin
            chk({tag, " c"},   int'(tim_c[g*4 +: 4]),   rc[g]);
            chk({tag, " pre"}, int'(tim_pre[g*4 +: 4]), rpre[g]);
            chk({tag, " ph"},  int'(tim_ph[g*2 +: 2]),  rph[g]);
            chk({tag, " t"},   int'(tim_t[g*4 +: 4]),   rt[g]);
            chk({tag, " p"},   int'(tim_p[g*3 +: 3]),   rp[g]);
            chk("R9 range", int'(tim_t[g*4 +: 4] < 4'(TB)) + int'(tim_p[g*3 +: 3] < 3'(PB - 1)
                || tim_p[g*3 +: 3] == 3'(PB - 1)), 2);
        end
    endtask

    task automatic run_case(input int cas, input bit cf, input int md, input int lt, input string tag);
        int cnt = 0;
        mode = md; lat = lt;
        ref_run(cas, cf);
        cas_lat = 4'(cas); card_f = cf;
        nprobe = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R1: loaded tuples right after the start edge
        for (int g = 0; g < NG; g++) begin
            chk("R1 init c", int'(tim_c[g*4 +: 4]), cas + 1);
            chk("R1 init rest", int'({tim_pre[g*4 +: 4], tim_ph[g*2 +: 2], tim_t[g*4 +: 4], tim_p[g*3 +: 3]}), 0);
        end
        chk("R1 flags", int'({done, err}), 0);
        while (!(done || err) && cnt < 40000) begin @(negedge clk); cnt++; end
        chk("R2 finished", int'(done || err), 1);
        chk("R2 probe count", nprobe, rprobes);
        chk({tag, " done"}, int'(done), ab ? 0 : 1);
        chk({tag, " err"}, int'(err), ab ? 1 : 0);
        cmp_tuples(ab ? tag : "R3 R4 R5 R6 R8 R7");
        repeat (5) @(negedge clk);
        chk("R12 flags hold", int'({done, err, probe_req}), ab ? 2 : 4);
        chk("R12 no probe after end", nprobe, rprobes);
        cmp_tuples("R12 hold");
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; cas_lat = 4'd0; card_f = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 reset flags", int'({done, err, probe_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle no probe", int'(probe_req), 0);

        for (int cs = 0; cs < 2; cs++) begin
            for (int cf = 0; cf < 2; cf++) begin
                for (int k = 0; k < 6; k++) begin
                    automatic int cas = cs ? 5 : 3;
                    automatic int u0 = (cas + 1) * CLKU;
                    for (int g = 0; g < NG; g++) begin
                        if (k == 5) e0[g] = u0 - 20 - 9 * g;
                        else        e0[g] = u0 + 40 + 37 * k + 61 * g;
                        e1[g] = e0[g] + ((k * 7 + g * 5) % 25);
                    end
                    run_case(cas, cf[0], 0, k % 3, "R7");
                end
            end
        end

        // R10: clock count overflow with strobe stuck high
        run_case(14, 1'b0, 2, 1, "R10");
        chk("R10 probes", nprobe, 4);
        // R11: second lane never high, fine search exhausts its limit
        for (int g = 0; g < NG; g++) begin
            e0[g] = 4 * CLKU + 100 + 30 * g; e1[g] = e0[g];
        end
        run_case(3, 1'b0, 1, 0, "R11");
        chk("R11 err", int'(err), 1);
        // R1: restart from error
        run_case(4, 1'b1, 0, 2, "R7");

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule